// File: doc/BRIEF.md
# Dual-Panel LCD Refresh Timing and Address Generator

This block produces the complete refresh timing for a dot-matrix LCD whose panel is split into an upper and a lower half that are scanned in parallel. It runs on the dot clock and divides it into character periods of Hp dots. A line holds HN active characters followed by a fixed eight-character gap in which no pattern data moves. Within each character period the display memory address is time-shared: the upper-half address is presented while the character clock is low and the lower-half address while it is high.

Line and frame counters step the line start address by HN per character row. In graphics mode that happens on every line. In character mode one row of addresses is repeated for Vp raster lines while a raster address counts up. The gap supplies the line latch, the driver chip-enable pulse and a busy window in which a CPU may access display memory without visible disturbance. A frame marker and a per-frame alternating signal drive the row drivers. When display refresh is disabled, a CPU address is passed to the memory address output. A separate enable gates the address outputs.

Top module: `lcd_refresh_gen`

## Requirements
- R1: The character clock has a period of Hp = hp_m1_i+1 dot clocks. With d the dot index (0 at the start of the period), it is low while d ≤ floor(hp_m1_i/2) and high for the rest of the period.
- R2: A line lasts HN+8 character periods, where HN = hn_m1_i+1. Characters with index HN to HN+7 form the gap, and the address keeps counting through the gap.
- R3: While refresh is enabled, mem_addr_o equals the upper line base plus the character index when the character clock is low. It equals the lower line base plus the character index when the clock is high.
- R4: In graphics mode (gfx_mode_i=1) both line bases advance by HN at every line end and raster_o stays 0. The lower base starts a frame at start + Vr·HN, where Vr = duty_m1_i+1.
- R5: In character mode, raster_o counts 0 to vp_m1_i and the bases advance by HN only when a line ends with raster_o at vp_m1_i. The lower base starts a frame at start + (Vr/Vp)·HN.
- R6: With g = character index − HN during the gap, busy_o is high for g in 1..7, line_latch_o for g in 0..1 and chip_en_o for g = 2. All three are low during active characters.
- R7: A frame spans Vr lines. frame_o is high throughout the first line of each frame, and frame_alt_o inverts at every frame end.
- R8: When disp_en_i is 0, mem_addr_o equals cpu_addr_i in the same cycle.
- R9: addr_oe_o follows addr_en_i combinationally.
- R10: Reset clears all counters and frame_alt_o. The first cycle after reset loads both bases from start_addr_i and the dot count starts on the next cycle. A change of start_addr_i takes effect only at the next frame start, when mem_addr_o shows the new start in the first dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hp_m1_i | input | 3 | Hp − 1, dots per character (Hp 4..8) |
| vp_m1_i | input | 4 | Vp − 1, raster lines per character row |
| hn_m1_i | input | 7 | HN − 1, characters per line (HN 2..128) |
| duty_m1_i | input | 8 | Vr − 1, lines per panel half (Vr 2..256) |
| gfx_mode_i | input | 1 | 1 graphics, 0 character mode |
| start_addr_i | input | 16 | Display start address |
| disp_en_i | input | 1 | 1 refresh address out, 0 CPU address out |
| cpu_addr_i | input | 16 | CPU address for bypass |
| addr_en_i | input | 1 | Address output enable request |
| chr_clk_o | output | 1 | Character clock |
| mem_addr_o | output | 16 | Display memory address |
| raster_o | output | 4 | Raster address within character row |
| addr_oe_o | output | 1 | Enable for mem_addr_o and raster_o |
| line_latch_o | output | 1 | Line data latch pulse |
| chip_en_o | output | 1 | Segment driver chip-enable clock |
| busy_o | output | 1 | Gap window free for CPU access |
| frame_o | output | 1 | High during first line of a frame |
| frame_alt_o | output | 1 | Alternating frame signal |

## Verification
The assertions assume that Hp, Vp, HN, duty and mode stay constant outside reset and that, in character mode, Vr is a whole multiple of Vp. They also assume that Hp lies between 4 and 8. The bench changes these settings only while reset is held, and every table entry satisfies the multiple rule and the Hp range. Only the start address, the CPU address and the two enables move while the block runs, and the bench changes them between clock edges.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;
  localparam int GAP_CHARS   = 8;  // suspension length per line
  localparam int LATCH_CHARS = 2;  // latch high for gap slots 0..LATCH_CHARS-1
  localparam int CE_SLOT     = 2;  // chip-enable gap slot
  localparam int BUSY_FIRST  = 1;  // busy from this gap slot to end of gap
endpackage

// File: rtl/lcd_dot_div.sv
module lcd_dot_div #(
  parameter int HP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [HP_W-1:0] hp_m1_i,
  output logic            tick_o,
  output logic            chr_clk_o
);
  logic [HP_W-1:0] dot_q;

  assign tick_o    = run_i && (dot_q == hp_m1_i);
  assign chr_clk_o = dot_q > (hp_m1_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dot_q <= '0;
    else if (run_i) dot_q <= (dot_q == hp_m1_i) ? '0 : dot_q + 1'b1;
  end

  a_r1_dot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= hp_m1_i);
  a_r1_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chr_clk_o) |-> $past(tick_o));
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_refresh_pkg::*;
#(
  parameter int HN_W  = 7,
  localparam int COL_W = HN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [HN_W-1:0]  hn_m1_i,
  output logic [COL_W-1:0] col_o,
  output logic             line_end_o,
  output logic             busy_o,
  output logic             latch_o,
  output logic             ce_o
);
  logic [COL_W-1:0] col_q, hn, last, gap_idx;
  logic             in_gap;

  assign hn      = {1'b0, hn_m1_i} + 1'b1;
  assign last    = {1'b0, hn_m1_i} + COL_W'(GAP_CHARS);
  assign in_gap  = col_q >= hn;
  assign gap_idx = col_q - hn;

  assign busy_o     = in_gap && (gap_idx >= COL_W'(BUSY_FIRST));
  assign latch_o    = in_gap && (gap_idx <  COL_W'(LATCH_CHARS));
  assign ce_o       = in_gap && (gap_idx == COL_W'(CE_SLOT));
  assign line_end_o = tick_i && (col_q == last);
  assign col_o      = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     col_q <= '0;
    else if (tick_i) col_q <= (col_q == last) ? '0 : col_q + 1'b1;
  end

  a_r2_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= last);
  a_r6_busy_in_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (col_q >= hn));
  a_r6_latch_ce_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(latch_o && ce_o));
  a_r2_end_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |-> busy_o);
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int ADDR_W = 16,
  parameter int HN_W   = 7,
  parameter int VP_W   = 4,
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              line_end_i,
  input  logic [HN_W-1:0]   hn_m1_i,
  input  logic [VP_W-1:0]   vp_m1_i,
  input  logic [DUTY_W-1:0] duty_m1_i,
  input  logic              gfx_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] lbase_o,
  output logic [VP_W-1:0]   raster_o,
  output logic              first_line_o,
  output logic              alt_o,
  output logic              frame_end_o
);
  logic [DUTY_W:0]    lines, rows, vp_n;
  logic [ADDR_W-1:0]  hn_a, offset, base_q, lbase_q;
  logic [DUTY_W-1:0]  row_q;
  logic [VP_W-1:0]    ras_q;
  logic               alt_q;

  assign lines  = {1'b0, duty_m1_i} + 1'b1;
  assign vp_n   = (DUTY_W+1)'(vp_m1_i) + 1'b1;
  assign rows   = gfx_i ? lines : lines / vp_n;  // sampled only at frame load
  assign hn_a   = ADDR_W'(hn_m1_i) + 1'b1;
  assign offset = ADDR_W'(rows) * hn_a;

  assign frame_end_o  = line_end_i && (row_q == duty_m1_i);
  assign first_line_o = row_q == '0;
  assign base_o       = base_q;
  assign lbase_o      = lbase_q;
  assign raster_o     = ras_q;
  assign alt_o        = alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      ras_q   <= '0;
      base_q  <= '0;
      lbase_q <= '0;
      alt_q   <= 1'b0;
    end else if (load_i || frame_end_o) begin
      row_q   <= '0;
      ras_q   <= '0;
      base_q  <= start_i;
      lbase_q <= start_i + offset;
      if (frame_end_o) alt_q <= ~alt_q;
    end else if (line_end_i) begin
      row_q <= row_q + 1'b1;
      if (gfx_i || ras_q == vp_m1_i) begin
        ras_q   <= '0;
        base_q  <= base_q + hn_a;
        lbase_q <= lbase_q + hn_a;
      end else begin
        ras_q <= ras_q + 1'b1;
      end
    end
  end

  a_r5_raster_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_q <= vp_m1_i);
  a_r4_gfx_raster_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gfx_i |-> (ras_q == '0));
  a_r7_alt_at_frame_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alt_q) |-> $past(frame_end_o));
  a_r7_first_line_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> first_line_o);
  a_r10_base_holds_midline: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$past(line_end_i)) |-> $stable(base_q));
endmodule

// File: rtl/lcd_refresh_gen.sv
module lcd_refresh_gen #(
  parameter int ADDR_W = 16,
  parameter int HP_W   = 3,
  parameter int VP_W   = 4,
  parameter int HN_W   = 7,
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HP_W-1:0]   hp_m1_i,
  input  logic [VP_W-1:0]   vp_m1_i,
  input  logic [HN_W-1:0]   hn_m1_i,
  input  logic [DUTY_W-1:0] duty_m1_i,
  input  logic              gfx_mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              disp_en_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              addr_en_i,
  output logic              chr_clk_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [VP_W-1:0]   raster_o,
  output logic              addr_oe_o,
  output logic              line_latch_o,
  output logic              chip_en_o,
  output logic              busy_o,
  output logic              frame_o,
  output logic              frame_alt_o
);
  localparam int COL_W = HN_W + 1;

  logic              pend_q, tick, line_end, frame_end;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] base, lbase, refresh_addr;

  // one load cycle after reset to pick up the start address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b1;
    else         pend_q <= 1'b0;
  end

  lcd_dot_div #(.HP_W(HP_W)) u_dot (
    .clk_i, .rst_ni, .run_i(!pend_q), .hp_m1_i,
    .tick_o(tick), .chr_clk_o
  );

  lcd_line_timer #(.HN_W(HN_W)) u_line (
    .clk_i, .rst_ni, .tick_i(tick), .hn_m1_i,
    .col_o(col), .line_end_o(line_end), .busy_o,
    .latch_o(line_latch_o), .ce_o(chip_en_o)
  );

  lcd_frame_seq #(.ADDR_W(ADDR_W), .HN_W(HN_W), .VP_W(VP_W), .DUTY_W(DUTY_W)) u_frame (
    .clk_i, .rst_ni, .load_i(pend_q), .line_end_i(line_end),
    .hn_m1_i, .vp_m1_i, .duty_m1_i, .gfx_i(gfx_mode_i), .start_i(start_addr_i),
    .base_o(base), .lbase_o(lbase), .raster_o, .first_line_o(frame_o),
    .alt_o(frame_alt_o), .frame_end_o(frame_end)
  );

  assign refresh_addr = (chr_clk_o ? lbase : base) + ADDR_W'(col);
  assign mem_addr_o   = disp_en_i ? refresh_addr : cpu_addr_i;
  assign addr_oe_o    = addr_en_i;

  a_r10_load_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> !pend_q);
  a_r7_frame_end_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |-> tick);
endmodule

// File: tb/sim_lcd_refresh_gen.sv
module sim_lcd_refresh_gen;
  localparam int NCFG = 5;
  // stimulus: hp_m1, vp_m1, hn_m1, duty_m1, gfx, start; expected: lower-half offset
  localparam int T_HP[NCFG]    = '{7, 3, 4, 5, 6};
  localparam int T_VP[NCFG]    = '{0, 0, 2, 1, 15};
  localparam int T_HN[NCFG]    = '{3, 1, 2, 4, 1};
  localparam int T_DUTY[NCFG]  = '{5, 1, 5, 7, 15};
  localparam int T_GFX[NCFG]   = '{1, 1, 0, 0, 0};
  localparam int T_START[NCFG] = '{16'h0100, 16'hFFF0, 16'h0020, 16'h1000, 16'h0000};
  localparam int T_OFF[NCFG]   = '{24, 4, 6, 20, 2};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni;
  logic [2:0]  hp_m1;
  logic [3:0]  vp_m1;
  logic [6:0]  hn_m1;
  logic [7:0]  duty_m1;
  logic        gfx;
  logic [15:0] start_addr, cpu_addr;
  logic        disp_en, addr_en;
  logic        chr_clk, addr_oe, latch, ce, busy, frame, alt;
  logic [15:0] mem_addr;
  logic [3:0]  raster;

  lcd_refresh_gen u0 (
    .clk_i(clk), .rst_ni, .hp_m1_i(hp_m1), .vp_m1_i(vp_m1), .hn_m1_i(hn_m1),
    .duty_m1_i(duty_m1), .gfx_mode_i(gfx), .start_addr_i(start_addr),
    .disp_en_i(disp_en), .cpu_addr_i(cpu_addr), .addr_en_i(addr_en),
    .chr_clk_o(chr_clk), .mem_addr_o(mem_addr), .raster_o(raster),
    .addr_oe_o(addr_oe), .line_latch_o(latch), .chip_en_o(ce), .busy_o(busy),
    .frame_o(frame), .frame_alt_o(alt)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_dot, m_col, m_row, m_ras, c_idx;
  logic [15:0] m_base, m_lbase;
  bit m_alt, m_pend;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(output bit reloaded);
    int hn;
    hn = T_HN[c_idx] + 1;
    reloaded = 1'b0;
    if (m_pend) begin
      m_base = start_addr; m_lbase = start_addr + 16'(T_OFF[c_idx]);
      m_pend = 1'b0; reloaded = 1'b1;
    end else if (m_dot == T_HP[c_idx]) begin
      m_dot = 0;
      if (m_col == hn + 7) begin
        m_col = 0;
        if (m_row == T_DUTY[c_idx]) begin
          m_row = 0; m_ras = 0; m_alt = !m_alt; reloaded = 1'b1;
          m_base = start_addr; m_lbase = start_addr + 16'(T_OFF[c_idx]);
        end else begin
          m_row++;
          if (T_GFX[c_idx] == 1 || m_ras == T_VP[c_idx]) begin
            m_ras = 0; m_base = m_base + 16'(hn); m_lbase = m_lbase + 16'(hn);
          end else m_ras++;
        end
      end else m_col++;
    end else m_dot++;
  endtask

  task automatic compare(input bit reloaded);
    int hn, g;
    bit e_chr, in_gap;
    logic [15:0] e_addr;
    hn = T_HN[c_idx] + 1;
    e_chr = m_dot > (T_HP[c_idx] / 2);
    in_gap = m_col >= hn;
    g = m_col - hn;
    chk(chr_clk == e_chr, "R1 chr_clk", chr_clk, e_chr);
    e_addr = (e_chr ? m_lbase : m_base) + 16'(m_col);
    if (disp_en) chk(mem_addr == e_addr, T_GFX[c_idx] == 1 ? "R3 R4 mem_addr" : "R3 R5 mem_addr", mem_addr, e_addr);
    else         chk(mem_addr == cpu_addr, "R8 cpu bypass", mem_addr, cpu_addr);
    if (reloaded && disp_en) chk(mem_addr == start_addr, "R10 frame start address", mem_addr, start_addr);
    chk(raster == 4'(m_ras), T_GFX[c_idx] == 1 ? "R4 raster" : "R5 raster", raster, m_ras);
    chk(busy  == (in_gap && g >= 1), "R6 busy R2 gap", busy, in_gap && g >= 1);
    chk(latch == (in_gap && g <= 1), "R6 latch", latch, in_gap && g <= 1);
    chk(ce    == (in_gap && g == 2), "R6 chip_en", ce, in_gap && g == 2);
    chk(frame == (m_row == 0), "R7 frame", frame, m_row == 0);
    chk(alt   == m_alt, "R7 alt", alt, m_alt);
    chk(addr_oe == addr_en, "R9 oe", addr_oe, addr_en);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; disp_en = 1'b1; addr_en = 1'b1; cpu_addr = '0;
    hp_m1 = '0; vp_m1 = '0; hn_m1 = '0; duty_m1 = '0; gfx = 1'b1; start_addr = '0;
    for (int c = 0; c < NCFG; c++) begin
      int frame_cyc, total;
      bit rl;
      c_idx = c;
      @(negedge clk);
      rst_ni = 1'b0;
      hp_m1 = 3'(T_HP[c]); vp_m1 = 4'(T_VP[c]); hn_m1 = 7'(T_HN[c]);
      duty_m1 = 8'(T_DUTY[c]); gfx = 1'(T_GFX[c]); start_addr = 16'(T_START[c]);
      disp_en = 1'b1; addr_en = 1'b1;
      m_dot = 0; m_col = 0; m_row = 0; m_ras = 0; m_base = '0; m_lbase = '0;
      m_alt = 1'b0; m_pend = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(mem_addr == 16'h0 && !chr_clk && raster == 0, "R10 reset address", mem_addr, 0);
      chk(!busy && !latch && !ce && frame && !alt, "R10 reset strobes",
          {busy, latch, ce, frame, alt}, 5'b00010);
      rst_ni = 1'b1;
      frame_cyc = (T_HN[c] + 9) * (T_HP[c] + 1) * (T_DUTY[c] + 1);
      total = 2 * frame_cyc + 40;
      for (int cyc = 0; cyc < total; cyc++) begin
        @(posedge clk);
        model_step(rl);
        @(negedge clk);
        compare(rl);
        disp_en = !(cyc >= 100 && cyc < 120);
        addr_en = !(cyc >= 130 && cyc < 140);
        cpu_addr = 16'(cyc * 37 + 5);
        if (cyc == frame_cyc / 2) start_addr = start_addr + 16'h0040;  // R10 deferred
      end
    end
    finish_run();
  end
endmodule